// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This controller sits between a data cache and a 32-bit external bus on the processor side. When an operand read misses, it runs the bus cycles that fetch the operand. It decides whether to ask the memory for a burst that fills the whole four-long-word line, and it writes every returned long word into the cache through a write port. The cache array, the tag compare and the memory itself are outside the block.

A burst starts at the long word that holds the requested byte and wraps modulo four on address bits [3:2]. The bus address stays at the original request address for the whole burst, so the memory side has to advance the word select itself.

An operand can straddle two long words. If both halves are in the same line, the burst on the first half normally brings in the second half too. If the halves are in different lines, the first half is fetched as a single long word with no burst request, and the second half opens a burst on the next line. The execution unit gets a strobe as soon as the first long word arrives. An abnormal termination clears the valid bit of the word it hit, ends any burst, and triggers a single refetch when the operand word was lost.

The four states and their transitions are:

- `ST_IDLE` goes to `ST_LEAD` when a request is accepted.
- `ST_LEAD` is the first-portion cycle. It goes to `ST_BURST` on an acknowledged burst, to `ST_TRAIL` when the access is split, or back to `ST_IDLE`.
- `ST_BURST` covers the remaining beats. It goes to `ST_TRAIL` when the operand's second word was lost, otherwise to `ST_IDLE`.
- `ST_TRAIL` is the second-portion cycle. It goes to `ST_BURST` on an acknowledged cross-line burst, otherwise to `ST_IDLE`.

Top module: `line_burst_fill`

## Requirements
- R1: While reset is applied and whenever idle, req_ready is 1, and bus_req, cwr_en, first_rdy, op_done and op_err are 0.
- R2: A request is taken only on a rising edge where req_ready and req_valid are both 1. In the next cycle bus_req rises with bus_addr equal to the request byte address. req_valid while busy is ignored and is not queued.
- R3: req_size encodes the operand length: 0 is one byte, 1 is two bytes, 2 and 3 are four bytes. An access is split when req_addr[1:0] plus the length exceeds 4. Its second portion uses the next long-word address.
- R4: bus_burst_req is 1 during the first-portion cycle, except when the access is split and req_addr[3:2] is 3 (the halves are in different lines). In that case the first portion is a single-entry load.
- R5: A burst continues past the first cycle only if bus_burst_ack is 1 in the same cycle as bus_term. Otherwise the cycle is a single-entry load.
- R6: Writes use cwr_word = (start word + beat) modulo 4, where the start word is bits [3:2] of the cycle's address. cwr_index is address bits [11:4] of that portion.
- R7: bus_addr does not change from the first cycle of a burst to its last beat.
- R8: first_rdy pulses only in the cycle where the first-portion cycle terminates normally. In that cycle cwr_en and cwr_valid are 1 and cwr_data equals bus_rdata.
- R9: For a split access within one line, no second bus cycle occurs when the burst delivered the second word. The second-portion address appears on the bus only after the burst has ended.
- R10: For a split access across lines, the second-portion cycle asserts bus_burst_req. When acknowledged, it fills words 0, 1, 2, 3 of the next line in that order.
- R11: bus_abort during a burst beat writes that word with cwr_valid 0 and ends the burst with no further writes. If the operand's second word was on that beat, a single-entry cycle for it follows.
- R12: bus_abort on a first- or second-portion cycle writes that word with cwr_valid 0 and ends the operation with op_done and op_err both 1.
- R13: op_done pulses once per operation, in the cycle of its last bus termination. op_err is 0 unless R12 applies. req_ready is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand read request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand length code |
| req_ready | output | 1 | Controller idle, request may be taken |
| bus_req | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W | Bus address, held through a burst |
| bus_burst_req | output | 1 | Burst fill requested |
| bus_burst_ack | input | 1 | Memory accepts the burst |
| bus_term | input | 1 | Normal cycle termination |
| bus_abort | input | 1 | Abnormal cycle termination |
| bus_rdata | input | DATA_W | Read data |
| cwr_en | output | 1 | Cache word write strobe |
| cwr_index | output | IDX_W | Cache line index |
| cwr_word | output | log2(LINE_WORDS) | Long word within the line |
| cwr_data | output | DATA_W | Data to store |
| cwr_valid | output | 1 | Valid bit to store with the word |
| first_rdy | output | 1 | First long word available to the execution unit |
| op_done | output | 1 | Operand read finished |
| op_err | output | 1 | Operand read ended abnormally |

## Verification
Every cache write, first_rdy, op_done and op_err shows up combinationally in the same cycle as the termination input that causes it. The next state and the next bus address take effect one rising edge later. req_ready and the first bus cycle follow acceptance by one edge. The bench therefore drives bus responses at the falling edge and samples every output 2 ns later, still before the next rising edge. It checks req_ready one full cycle after op_done. Wait states from the responder postpone each result to the cycle that carries the termination, and the sampling follows that cycle.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_BURST = 2'd2,
        ST_TRAIL = 2'd3
    } fill_state_e;

    // Operand length in bytes; the reserved code is treated as a long word.
    function automatic logic [2:0] size_bytes(input op_size_e s);
        logic [2:0] n;
        unique case (s)
            SZ_BYTE: n = 3'd1;
            SZ_HALF: n = 3'd2;
            SZ_LONG: n = 3'd4;
            SZ_RSVD: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lbf_split.sv
// Decodes whether an operand straddles two long words and whether the
// second long word lives in the next cache line.
module lbf_split
    import lbf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              split,
    output logic              xline,
    output logic [ADDR_W-1:0] addr_next
);

    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int HI_W   = ADDR_W - 2;

    logic [3:0] span;
    logic       line_end;

    always_comb begin
        span      = {2'b00, addr[1:0]} + {1'b0, size_bytes(op_size_e'(size))};
        split     = span > 4'd4;
        line_end  = &addr[WSEL_W+1:2];
        xline     = split && line_end;
        addr_next = {addr[ADDR_W-1:2] + HI_W'(1), 2'b00};
    end

endmodule

// File: rtl/lbf_beat.sv
// Counts burst beats; beat 0 is the initiating cycle.
module lbf_beat #(
    parameter int LINE_WORDS = 4,
    parameter int WSEL_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [WSEL_W-1:0] cnt,
    output logic              last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= WSEL_W'(1);
        end else if (step) begin
            cnt <= cnt + WSEL_W'(1);
        end
    end

    assign last = (cnt == WSEL_W'(LINE_WORDS - 1));

endmodule

// File: rtl/lbf_wrap.sv
// Word select for a beat: start word plus beat, wrapping within the line.
module lbf_wrap #(
    parameter int WSEL_W = 2
) (
    input  logic [WSEL_W-1:0] start_word,
    input  logic [WSEL_W-1:0] beat,
    output logic [WSEL_W-1:0] word
);

    assign word = start_word + beat;

endmodule

// File: rtl/line_burst_fill.sv
module line_burst_fill
    import lbf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int IDX_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [1:0]                    req_size,
    output logic                          req_ready,
    output logic                          bus_req,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic                          bus_burst_req,
    input  logic                          bus_burst_ack,
    input  logic                          bus_term,
    input  logic                          bus_abort,
    input  logic [DATA_W-1:0]             bus_rdata,
    output logic                          cwr_en,
    output logic [IDX_W-1:0]              cwr_index,
    output logic [$clog2(LINE_WORDS)-1:0] cwr_word,
    output logic [DATA_W-1:0]             cwr_data,
    output logic                          cwr_valid,
    output logic                          first_rdy,
    output logic                          op_done,
    output logic                          op_err
);

    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + 2;

    fill_state_e       state, nxt;
    logic [ADDR_W-1:0] op_addr;
    logic [1:0]        op_size;
    logic              second, nxt_second;

    logic              split_op, xline_op;
    logic [ADDR_W-1:0] addr_next;
    logic [ADDR_W-1:0] cur_addr;

    logic              beat_load, beat_step;
    logic [WSEL_W-1:0] beat_cnt;
    logic              beat_last;
    logic [WSEL_W-1:0] beat_sel;
    logic [WSEL_W-1:0] word_sel;

    logic              accept;
    logic              ok_end;
    logic              bad_end;
    logic              lead_burst;
    logic              trail_burst;
    logic              lost_second;

    lbf_split #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_split (
        .addr      (op_addr),
        .size      (op_size),
        .split     (split_op),
        .xline     (xline_op),
        .addr_next (addr_next)
    );

    lbf_beat #(
        .LINE_WORDS (LINE_WORDS),
        .WSEL_W     (WSEL_W)
    ) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (beat_load),
        .step  (beat_step),
        .cnt   (beat_cnt),
        .last  (beat_last)
    );

    lbf_wrap #(
        .WSEL_W (WSEL_W)
    ) u_wrap (
        .start_word (cur_addr[OFF_W-1:2]),
        .beat       (beat_sel),
        .word       (word_sel)
    );

    // Shared decode used by the next-state and output processes.
    always_comb begin
        accept      = (state == ST_IDLE) && req_valid;
        bad_end     = bus_abort;
        ok_end      = bus_term && !bus_abort;
        cur_addr    = second ? addr_next : op_addr;
        beat_sel    = (state == ST_BURST) ? beat_cnt : '0;
        lead_burst  = !(split_op && xline_op);
        trail_burst = xline_op;
        // Only beat 1 of a first-portion burst carries the operand's second word.
        lost_second = bad_end && (beat_cnt == WSEL_W'(1));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_addr <= '0;
            op_size <= 2'd0;
            second  <= 1'b0;
        end else begin
            state  <= nxt;
            second <= nxt_second;
            if (accept) begin
                op_addr <= req_addr;
                op_size <= req_size;
            end
        end
    end

    // Next-state process
    always_comb begin
        nxt        = state;
        nxt_second = second;
        beat_load  = 1'b0;
        beat_step  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt        = ST_LEAD;
                    nxt_second = 1'b0;
                end
            end
            ST_LEAD: begin
                if (bad_end) begin
                    nxt = ST_IDLE;
                end else if (ok_end) begin
                    if (lead_burst && bus_burst_ack) begin
                        nxt       = ST_BURST;
                        beat_load = 1'b1;
                    end else if (split_op) begin
                        nxt        = ST_TRAIL;
                        nxt_second = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_BURST: begin
                if (bad_end || (ok_end && beat_last)) begin
                    if (!second && split_op && lost_second) begin
                        nxt        = ST_TRAIL;
                        nxt_second = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else if (ok_end) begin
                    beat_step = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (bad_end) begin
                    nxt = ST_IDLE;
                end else if (ok_end) begin
                    if (trail_burst && bus_burst_ack) begin
                        nxt       = ST_BURST;
                        beat_load = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // Output process
    always_comb begin
        req_ready     = 1'b0;
        bus_req       = 1'b0;
        bus_burst_req = 1'b0;
        first_rdy     = 1'b0;
        op_err        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LEAD: begin
                bus_req       = 1'b1;
                bus_burst_req = lead_burst;
                first_rdy     = ok_end;
                op_err        = bad_end;
            end
            ST_BURST: begin
                bus_req       = 1'b1;
                bus_burst_req = 1'b1;
            end
            ST_TRAIL: begin
                bus_req       = 1'b1;
                bus_burst_req = trail_burst;
                op_err        = bad_end;
            end
        endcase
        bus_addr  = cur_addr;
        cwr_en    = bus_req && (bus_term || bus_abort);
        cwr_valid = bus_req && ok_end;
        cwr_index = cur_addr[OFF_W +: IDX_W];
        cwr_word  = word_sel;
        cwr_data  = bus_rdata;
        op_done   = bus_req && (nxt == ST_IDLE);
    end

endmodule

// File: rtl/lbf_chk.sv
module lbf_chk
    import lbf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input fill_state_e       state,
    input logic              xline_op,
    input logic              req_ready,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_term,
    input logic              bus_abort,
    input logic              cwr_en,
    input logic              cwr_valid,
    input logic [WSEL_W-1:0] cwr_word,
    input logic              first_rdy,
    input logic              op_done
);

    logic [WSEL_W-1:0] last_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_w <= '0;
        end else if (cwr_en) begin
            last_w <= cwr_word;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !cwr_en)) else $error("idle bus activity"); // R1

    AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && xline_op && bus_term && !bus_abort) |=> (state == ST_TRAIL)) else $error("cross-line first portion burst"); // R4

    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && cwr_en) |-> (cwr_word == WSEL_W'(last_w + WSEL_W'(1)))) else $error("burst word order"); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST) |-> (bus_addr == $past(bus_addr))) else $error("address moved in burst"); // R7

    AST_FIRST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        first_rdy |-> (cwr_en && cwr_valid && state == ST_LEAD)) else $error("first strobe without data"); // R8

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && bus_abort) |=> (state != ST_BURST)) else $error("burst ran past abort"); // R11

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> req_ready) else $error("not idle after done"); // R13

endmodule

bind line_burst_fill lbf_chk #(
    .ADDR_W (ADDR_W),
    .WSEL_W ($clog2(LINE_WORDS))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .xline_op  (xline_op),
    .req_ready (req_ready),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_term  (bus_term),
    .bus_abort (bus_abort),
    .cwr_en    (cwr_en),
    .cwr_valid (cwr_valid),
    .cwr_word  (cwr_word),
    .first_rdy (first_rdy),
    .op_done   (op_done)
);

// File: tb/sim_line_burst_fill.sv
`timescale 1ns/1ps
module sim_line_burst_fill;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_ready, bus_req, bus_burst_req;
    logic [31:0] bus_addr;
    logic        bus_burst_ack = 1'b0;
    logic        bus_term = 1'b0;
    logic        bus_abort = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        cwr_en, cwr_valid, first_rdy, op_done, op_err;
    logic [7:0]  cwr_index;
    logic [1:0]  cwr_word;
    logic [31:0] cwr_data;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    line_burst_fill u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_ready     (req_ready),
        .bus_req       (bus_req),
        .bus_addr      (bus_addr),
        .bus_burst_req (bus_burst_req),
        .bus_burst_ack (bus_burst_ack),
        .bus_term      (bus_term),
        .bus_abort     (bus_abort),
        .bus_rdata     (bus_rdata),
        .cwr_en        (cwr_en),
        .cwr_index     (cwr_index),
        .cwr_word      (cwr_word),
        .cwr_data      (cwr_data),
        .cwr_valid     (cwr_valid),
        .first_rdy     (first_rdy),
        .op_done       (op_done),
        .op_err        (op_err)
    );

    // Each expected write is a nibble {valid, next_line, word[1:0]}, first write lowest.
    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  size;
        logic        ack;
        logic        waits;
        logic [3:0]  abort_at;
        logic [3:0]  n;
        logic [31:0] seq;
        logic [7:0]  breq;
        logic [7:0]  amask;
        logic        err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0106, 2'd2, 1'b1, 1'b0, 4'd0, 4'd4, 32'h0000_8BA9, 8'h0F, 8'h00, 1'b0}, // R9 split in line, wrap R6
        '{16'h0100, 2'd0, 1'b1, 1'b0, 4'd0, 4'd4, 32'h0000_BA98, 8'h0F, 8'h00, 1'b0}, // R6 aligned byte
        '{16'h010F, 2'd1, 1'b1, 1'b0, 4'd0, 4'd5, 32'h000F_EDCB, 8'h1E, 8'h1E, 1'b0}, // R4 R10 cross line
        '{16'h0108, 2'd2, 1'b0, 1'b0, 4'd0, 4'd1, 32'h0000_000A, 8'h01, 8'h00, 1'b0}, // R5 no ack
        '{16'h0104, 2'd2, 1'b1, 1'b0, 4'd3, 4'd3, 32'h0000_03A9, 8'h07, 8'h00, 1'b0}, // R11 abort beat 2
        '{16'h0107, 2'd1, 1'b1, 1'b0, 4'd2, 4'd3, 32'h0000_0A29, 8'h03, 8'h04, 1'b0}, // R11 lost second word
        '{16'h010C, 2'd2, 1'b1, 1'b0, 4'd1, 4'd1, 32'h0000_0003, 8'h01, 8'h00, 1'b1}, // R12 abort first
        '{16'h010E, 2'd2, 1'b0, 1'b0, 4'd0, 4'd2, 32'h0000_00CB, 8'h02, 8'h02, 1'b0}, // R3 R4 cross line no ack
        '{16'h010D, 2'd1, 1'b1, 1'b1, 4'd0, 4'd4, 32'h0000_A98B, 8'h0F, 8'h00, 1'b0}, // R7 wait states
        '{16'h010F, 2'd1, 1'b1, 1'b0, 4'd2, 4'd2, 32'h0000_004B, 8'h02, 8'h02, 1'b1}, // R12 abort second
        '{16'h010E, 2'd3, 1'b0, 1'b0, 4'd0, 4'd2, 32'h0000_00CB, 8'h02, 8'h02, 1'b0}  // R3 reserved size
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        int          cyc = 0;
        int          widx = 0;
        int          firsts = 0;
        int          left = 0;
        bit          fin = 1'b0;
        bit          wdone = 1'b0;
        logic [15:0] a2;
        logic [3:0]  nib;
        logic [11:0] lin;
        logic [1:0]  rw;
        logic [15:0] ea;
        a2 = {v.addr[15:2] + 14'd1, 2'b00};
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {16'h0000, v.addr};
        req_size  = v.size;
        for (int c = 0; c < 60 && !fin; c++) begin
            @(negedge clk);
            req_valid     = 1'b0;
            bus_term      = 1'b0;
            bus_abort     = 1'b0;
            bus_burst_ack = 1'b0;
            bus_rdata     = '0;
            if (bus_req) begin
                if (v.waits && !wdone) begin
                    wdone = 1'b1;
                end else begin
                    wdone = 1'b0;
                    cyc++;
                    if (cyc == int'(v.abort_at)) begin
                        bus_abort = 1'b1;
                    end else begin
                        bus_term      = 1'b1;
                        bus_burst_ack = v.ack;
                        rw        = bus_addr[3:2] + 2'(left > 0 ? 4 - left : 0);
                        bus_rdata = {16'hDA00, bus_addr[15:4], rw, 2'b00};
                    end
                end
            end
            #2;
            if (bus_term || bus_abort) begin
                ea = (cyc <= 8 && v.amask[cyc-1]) ? a2 : v.addr;
                chk(bus_addr == {16'h0, ea}, "R2 R7 R9 bus address", bus_addr, {16'h0, ea});
                chk(bus_burst_req == v.breq[cyc-1], "R4 R5 R10 burst request",
                    32'(bus_burst_req), 32'(v.breq[cyc-1]));
            end
            if (cwr_en) begin
                nib = v.seq[widx*4 +: 4];
                lin = v.addr[15:4] + 12'(nib[2]);
                chk(widx < int'(v.n), "R9 R11 extra write", 32'(widx), 32'(v.n));
                chk({cwr_valid, cwr_index, cwr_word} == {nib[3], lin[7:0], nib[1:0]},
                    "R6 R11 R12 word valid index", {21'h0, cwr_valid, cwr_index, cwr_word},
                    {21'h0, nib[3], lin[7:0], nib[1:0]});
                if (nib[3])
                    chk(cwr_data == {16'hDA00, lin, nib[1:0], 2'b00}, "R6 write data",
                        cwr_data, {16'hDA00, lin, nib[1:0], 2'b00});
                widx++;
            end
            if (first_rdy) begin
                firsts++;
                chk(cyc == 1 && cwr_data == bus_rdata, "R8 first strobe timing", 32'(cyc), 32'd1);
            end
            if (op_done) begin
                fin = 1'b1;
                chk(op_err == v.err, "R12 R13 error flag", 32'(op_err), 32'(v.err));
                chk(cyc == int'(v.n), "R13 done cycle", 32'(cyc), 32'(v.n));
            end else begin
                chk(op_err == 1'b0, "R13 stray error", 32'(op_err), 32'd0);
            end
            if (bus_abort) left = 0;
            else if (bus_term) begin
                if (left > 0) left--;
                else if (bus_burst_req && bus_burst_ack) left = 3;
            end
        end
        chk(fin, "R13 operation finished", 32'(fin), 32'd1);
        chk(widx == int'(v.n), "R9 R10 R11 write count", 32'(widx), 32'(v.n));
        chk(firsts == ((v.abort_at == 4'd1) ? 0 : 1), "R8 first strobe count", 32'(firsts),
            32'((v.abort_at == 4'd1) ? 0 : 1));
        @(negedge clk);
        bus_term = 1'b0; bus_abort = 1'b0; bus_burst_ack = 1'b0;
        #2;
        chk(req_ready == 1'b1 && bus_req == 1'b0, "R13 ready after done", 32'(req_ready), 32'd1);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !bus_req && !cwr_en && !first_rdy && !op_done && !op_err,
            "R1 in reset", {26'h0, req_ready, bus_req, cwr_en, first_rdy, op_done, op_err}, 32'h20);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(req_ready && !bus_req && !cwr_en && !first_rdy && !op_done && !op_err,
            "R1 after reset", {26'h0, req_ready, bus_req, cwr_en, first_rdy, op_done, op_err}, 32'h20);

        for (int i = 0; i < NV; i++) run_op(VECS[i]);

        // R2: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0208; req_size = 2'd2;
        @(negedge clk);
        req_addr = 32'h0000_0300;
        #2;
        chk(req_ready == 1'b0, "R2 busy not ready", 32'(req_ready), 32'd0);
        chk(bus_req && bus_addr == 32'h208, "R2 first cycle address", bus_addr, 32'h208);
        @(negedge clk);
        #2;
        chk(bus_addr == 32'h208, "R2 address kept while busy", bus_addr, 32'h208);
        @(negedge clk);
        req_valid = 1'b0;
        bus_term = 1'b1; bus_rdata = 32'h1234_5678;
        #2;
        chk(op_done && cwr_word == 2'd2 && cwr_valid, "R2 R5 single entry",
            {30'h0, cwr_word}, 32'd2);
        @(negedge clk);
        bus_term = 1'b0;
        #2;
        chk(req_ready && !bus_req, "R2 busy request not queued", 32'(bus_req), 32'd0);
        @(negedge clk);
        #2;
        chk(!bus_req, "R2 still idle", 32'(bus_req), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule